// File: doc/BRIEF.md
# Fixed-Segment Virtual-to-Physical Address Translator

This block turns a 32-bit virtual address into a physical address for a processor that has no translation lookaside buffer. The mapping depends only on which fixed segment the address falls in, so no table is consulted. Each result carries three things:

- a physical address;
- a flag that says whether the access may be cached;
- a flag that reports an illegal access.

The block also holds the privilege mode. It moves to kernel mode when an exception is taken and back to user mode when the return-from-exception pulse arrives.

Requests come in on a valid/ready stream and results leave on a valid/ready stream. There is one register stage between them.

- The input is accepted in any cycle where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the result register is empty, or whenever its content is being taken in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the result holds still and no new request is accepted.

The two mode pulses are plain control pins. They do not depend on the stream handshake.

Top module: `dseg_xlat`

## Requirements
- R1: After reset the mode is kernel (`kernel_mode` = 1), `out_valid` is 0 and `in_ready` is 1.
- R2: A high `exc_take` sets kernel mode from the next cycle on. It wins over a simultaneous `exc_return`.
- R3: A high `exc_return` alone sets user mode from the next cycle on. An access accepted in the same cycle as either pulse is translated in the old mode.
- R4: In either mode, a virtual address with bit 31 clear maps to the virtual address plus 0x4000_0000.
- R5: Within that lower segment, addresses 0x7F00_0000 to 0x7FFF_FFFF are reported not cacheable. The rest of the lower segment is cacheable.
- R6: In user mode, an address with bit 31 set gives `out_err` = 1, `out_pa` = 0 and `out_cache` = 0.
- R7: In kernel mode, 0x8000_0000 to 0x9FFF_FFFF maps with bit 31 cleared and is cacheable.
- R8: In kernel mode, 0xA000_0000 to 0xBFFF_FFFF maps with bits 31 to 29 cleared and is not cacheable.
- R9: In kernel mode, 0xC000_0000 to 0xFFFF_FFFF passes through unchanged and is cacheable.
- R10: The result of an accepted request appears at the output in the next cycle. The access type (00 fetch, 01 load, 10 store, 11 reserved) is echoed unchanged on `out_acc`.
- R11: While `out_valid` is high and `out_ready` is low, the output holds stable. Results leave in the order their requests were accepted, and none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_va | input | 32 | Virtual address |
| in_acc | input | 2 | Access type: 00 fetch, 01 load, 10 store |
| exc_take | input | 1 | Exception taken pulse |
| exc_return | input | 1 | Return-from-exception pulse |
| kernel_mode | output | 1 | Current mode, 1 = kernel |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_pa | output | 32 | Physical address |
| out_cache | output | 1 | Access is cacheable |
| out_err | output | 1 | Address error |
| out_acc | output | 2 | Echoed access type |

## Verification
The bench probes both sides of every segment edge:

- 0x7EFF_FFFF against 0x7F00_0000, and 0x7FFF_FFFF against 0x8000_0000;
- 0x9FFF_FFFF against 0xA000_0000, and 0xBFFF_FFFF against 0xC000_0000.

It does this in both modes. A design that decodes one bit too few would mark the wrong 16 MB as uncacheable, or would map a kernel segment with the wrong mask.

It places a mode pulse in the same cycle as an access. A design that uses the new mode too early would flag kernel accesses as errors, or would let a user access into the upper half.

It also drives both pulses at once, to expose a reversed priority. Finally, it throttles the output ready with a pseudo-random pattern. A result register that drops or repeats an entry under stall would then break the scoreboard order.

// File: rtl/dseg_xlat_pkg.sv
package dseg_xlat_pkg;

  parameter int unsigned XL_VA_W = 32;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    SEG_LOW   = 2'd0,
    SEG_KDIR  = 2'd1,
    SEG_KRAW  = 2'd2,
    SEG_KHIGH = 2'd3
  } seg_e;

  typedef struct packed {
    logic [XL_VA_W-1:0] pa;
    logic               cache;
    logic               err;
    acc_e               acc;
  } xl_res_t;

endpackage

// File: rtl/dseg_mode_reg.sv
module dseg_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_k,
  input  logic leave_k,
  output logic kmode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kmode <= 1'b1;
    end else if (enter_k) begin
      kmode <= 1'b1;
    end else if (leave_k) begin
      kmode <= 1'b0;
    end
  end
endmodule

// File: rtl/dseg_seg_decode.sv
module dseg_seg_decode
  import dseg_xlat_pkg::*;
#(
  parameter int unsigned VA_W        = XL_VA_W,
  parameter logic [VA_W-1:0] LOW_OFS = 32'h4000_0000,
  parameter int unsigned WIN_LOG2    = 24
) (
  input  logic [VA_W-1:0] va,
  input  acc_e            acc,
  input  logic            kmode,
  output xl_res_t         res
);
  localparam int unsigned TOP  = VA_W - 1;
  localparam int unsigned WTAG = TOP - WIN_LOG2;

  seg_e seg;
  logic [VA_W-1:0] pa_raw;
  logic cache_raw;
  logic illegal;

  always_comb begin
    if (!va[TOP])                   seg = SEG_LOW;
    else if (va[TOP-1])             seg = SEG_KHIGH;
    else if (va[TOP-2])             seg = SEG_KRAW;
    else                            seg = SEG_KDIR;
  end

  always_comb begin
    pa_raw    = va;
    cache_raw = 1'b1;
    unique case (seg)
      SEG_LOW: begin
        pa_raw    = va + LOW_OFS;
        cache_raw = ~(&va[TOP-1:WIN_LOG2]);
      end
      SEG_KDIR: begin
        pa_raw    = {1'b0, va[TOP-1:0]};
        cache_raw = 1'b1;
      end
      SEG_KRAW: begin
        pa_raw    = {3'b000, va[TOP-3:0]};
        cache_raw = 1'b0;
      end
      SEG_KHIGH: begin
        pa_raw    = va;
        cache_raw = 1'b1;
      end
      default: begin
        pa_raw    = va;
        cache_raw = 1'b1;
      end
    endcase
  end

  assign illegal = va[TOP] & ~kmode;

  always_comb begin
    res.acc   = acc;
    res.err   = illegal;
    res.pa    = illegal ? '0 : pa_raw;
    res.cache = illegal ? 1'b0 : cache_raw;
  end

  // Keeps the width relation visible; WTAG unused otherwise.
  logic unused_w;
  assign unused_w = (WTAG == 0);
endmodule

// File: rtl/dseg_out_stage.sv
module dseg_out_stage
  import dseg_xlat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    up_valid,
  output logic    up_ready,
  input  xl_res_t up_res,
  output logic    dn_valid,
  input  logic    dn_ready,
  output xl_res_t dn_res
);
  logic load;

  assign up_ready = ~dn_valid | dn_ready;
  assign load     = up_valid & up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_res <= '0;
    end else if (load) begin
      dn_res <= up_res;
    end
  end
endmodule

// File: rtl/dseg_xlat.sv
module dseg_xlat
  import dseg_xlat_pkg::*;
#(
  parameter int unsigned VA_W        = XL_VA_W,
  parameter logic [VA_W-1:0] LOW_OFS = 32'h4000_0000,
  parameter int unsigned WIN_LOG2    = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VA_W-1:0] in_va,
  input  logic [1:0]      in_acc,
  input  logic            exc_take,
  input  logic            exc_return,
  output logic            kernel_mode,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VA_W-1:0] out_pa,
  output logic            out_cache,
  output logic            out_err,
  output logic [1:0]      out_acc
);
  xl_res_t dec_res;
  xl_res_t reg_res;

  dseg_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .enter_k(exc_take),
    .leave_k(exc_return),
    .kmode  (kernel_mode)
  );

  dseg_seg_decode #(
    .VA_W    (VA_W),
    .LOW_OFS (LOW_OFS),
    .WIN_LOG2(WIN_LOG2)
  ) u_dec (
    .va   (in_va),
    .acc  (acc_e'(in_acc)),
    .kmode(kernel_mode),
    .res  (dec_res)
  );

  dseg_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_res  (dec_res),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_res  (reg_res)
  );

  assign out_pa    = reg_res.pa;
  assign out_cache = reg_res.cache;
  assign out_err   = reg_res.err;
  assign out_acc   = reg_res.acc;
endmodule

// File: rtl/dseg_xlat_chk.sv
module dseg_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_va,
  input logic        exc_take,
  input logic        exc_return,
  input logic        kernel_mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_pa,
  input logic        out_cache,
  input logic        out_err,
  input logic [1:0]  out_acc
);
  // R2
  exc_enters_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> kernel_mode);

  // R3
  ret_leaves_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_take) |=> !kernel_mode);

  // R2
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_take && !exc_return) |=> $stable(kernel_mode));

  // R6
  err_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_pa == 32'h0 && !out_cache));

  // R6
  user_upper_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !kernel_mode && in_va[31]) |=> (out_valid && out_err));

  // R10
  kernel_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && kernel_mode) |=> (out_valid && !out_err));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pa) && $stable(out_err)
                                   && $stable(out_cache) && $stable(out_acc)));
endmodule

bind dseg_xlat dseg_xlat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_va      (in_va),
  .exc_take   (exc_take),
  .exc_return (exc_return),
  .kernel_mode(kernel_mode),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pa     (out_pa),
  .out_cache  (out_cache),
  .out_err    (out_err),
  .out_acc    (out_acc)
);

// File: tb/dseg_xlat_tb.sv
module dseg_xlat_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_va = '0;
  logic [1:0]  in_acc = '0;
  logic        exc_take = 1'b0;
  logic        exc_return = 1'b0;
  logic        kernel_mode;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pa;
  logic        out_cache;
  logic        out_err;
  logic [1:0]  out_acc;

  typedef struct packed {
    logic [31:0] pa;
    logic        cache;
    logic        err;
    logic [1:0]  acc;
    logic [3:0]  req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   m_kern = 1'b1;
  bit   stall_en = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  dseg_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_va(in_va), .in_acc(in_acc), .exc_take(exc_take), .exc_return(exc_return),
    .kernel_mode(kernel_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_pa(out_pa), .out_cache(out_cache), .out_err(out_err), .out_acc(out_acc)
  );

  function automatic exp_t model(logic [31:0] va, logic [1:0] acc, bit kern);
    exp_t e;
    e.acc = acc;
    e.err = 1'b0;
    if (va <= 32'h7FFF_FFFF) begin
      e.pa    = va + 32'h4000_0000;
      e.cache = (va < 32'h7F00_0000);
      e.req   = (va >= 32'h7F00_0000) ? 4'd5 : 4'd4;
    end else if (!kern) begin
      e.pa = 32'h0; e.cache = 1'b0; e.err = 1'b1; e.req = 4'd6;
    end else if (va <= 32'h9FFF_FFFF) begin
      e.pa = va - 32'h8000_0000; e.cache = 1'b1; e.req = 4'd7;
    end else if (va <= 32'hBFFF_FFFF) begin
      e.pa = va - 32'hA000_0000; e.cache = 1'b0; e.req = 4'd8;
    end else begin
      e.pa = va; e.cache = 1'b1; e.req = 4'd9;
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // Drive an access, optionally with mode pulses in the same cycle (R3)
  task automatic send(logic [31:0] va, logic [1:0] acc, bit ex = 0, bit rt = 0);
    exp_t e;
    in_va = va; in_acc = acc; in_valid = 1'b1;
    exc_take = ex; exc_return = rt;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      exc_take = 1'b0; exc_return = 1'b0;
    end
    e = model(va, acc, m_kern);
    exp_q.push_back(e);
    @(posedge clk); #1;
    if (ex) m_kern = 1'b1; else if (rt) m_kern = 1'b0;
    in_valid = 1'b0; exc_take = 1'b0; exc_return = 1'b0;
  endtask

  task automatic pulse(bit ex, bit rt);
    exc_take = ex; exc_return = rt;
    @(posedge clk); #1;
    exc_take = 1'b0; exc_return = 1'b0;
    if (ex) m_kern = 1'b1; else if (rt) m_kern = 1'b0;
    @(negedge clk);
    check(kernel_mode == m_kern, ex ? "R2" : "R3", "kernel_mode", 64'(kernel_mode), 64'(m_kern));
    @(posedge clk); #1;
  endtask

  task automatic sweep(logic [1:0] acc);
    send(32'h0000_0000, acc);
    send(32'h7EFF_FFFF, acc);
    send(32'h7F00_0000, acc);
    send(32'h7FFF_FFFF, acc);
    send(32'h8000_0000, acc);
    send(32'h9FFF_FFFF, acc);
    send(32'hA000_0000, acc);
    send(32'hBFFF_FFFF, acc);
    send(32'hC000_0000, acc);
    send(32'hFFFF_FFFF, acc);
    send(32'h1234_5678, acc);
    send(32'hA123_4567, acc);
  endtask

  // Scoreboard monitor (R4..R11): a transfer occurs at the next edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected result", 64'(out_pa), 64'h0);
      end else begin
        exp_t e;
        string rq;
        e = exp_q.pop_front();
        rq = $sformatf("R%0d", e.req);
        check(out_pa == e.pa, rq, "out_pa", 64'(out_pa), 64'(e.pa));
        check(out_cache == e.cache, rq, "out_cache", 64'(out_cache), 64'(e.cache));
        check(out_err == e.err, rq, "out_err", 64'(out_err), 64'(e.err));
        check(out_acc == e.acc, "R10", "out_acc", 64'(out_acc), 64'(e.acc));
      end
    end
  end

  // Output throttling for R11
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = !stall_en || lfsr[0];
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R1 reset state
    check(kernel_mode == 1'b1, "R1", "kernel_mode", 64'(kernel_mode), 64'h1);
    check(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 64'h0);
    check(in_ready == 1'b1, "R1", "in_ready", 64'(in_ready), 64'h1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R7 R8 R9 R4 R5 in kernel mode
    sweep(2'b00);
    // R10 latency: result visible at the next sample
    in_va = 32'h8000_0010; in_acc = 2'b01; in_valid = 1'b1;
    @(negedge clk);
    exp_q.push_back(model(32'h8000_0010, 2'b01, m_kern));
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R10", "out_valid one cycle later", 64'(out_valid), 64'h1);
    @(posedge clk); #1;

    pulse(1'b0, 1'b1);   // R3 to user
    sweep(2'b01);        // R6 R4 R5 in user mode
    send(32'h9000_0000, 2'b10, 1'b1, 1'b0); // R3: old (user) mode applies -> error
    send(32'h9000_0000, 2'b10);             // now kernel -> R7
    send(32'hC000_0004, 2'b11, 1'b0, 1'b1); // R3: old (kernel) mode applies
    send(32'hC000_0004, 2'b11);             // now user -> R6
    pulse(1'b1, 1'b1);   // R2 priority -> kernel
    pulse(1'b0, 1'b1);   // back to user
    pulse(1'b1, 1'b0);   // R2 plain exception

    // R11 under back-pressure
    stall_en = 1'b1;
    sweep(2'b10);
    pulse(1'b0, 1'b1);
    sweep(2'b11);
    stall_en = 1'b0;

    repeat (20) @(posedge clk);
    check(exp_q.size() == 0, "R11", "results drained", 64'(exp_q.size()), 64'h0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule